// File: doc/BRIEF.md
# Memory-Ordering Dispatch Unit

This block sits at the dispatch stage of an out-of-order core and handles the memory side of each operation, one per cycle. Every operation carries three flags: it may read memory, it may write memory, and it has side effects. The unit first checks the occupancy of the load queue and the store queue and returns a two-bit availability code. If the code is zero, the operation is accepted. It then takes one entry in each queue it uses and receives a dependency group number. The unit also names up to three older groups that the new group must wait for before it may issue.

The ordering rules are weak. Stores stay in order with older stores and older loads. Plain loads may overtake older loads. Loads may overtake older stores only when the `NO_ALIAS` parameter is set. An operation that reads memory and has side effects is a load fence. An operation that writes memory and has side effects is a store fence. An operation that does both is a full fence.

A three-state machine decides whether a plain load may share the youngest load group:

- `LG_NONE`: no load group exists yet.
- `LG_OPEN`: the youngest load group holds only plain loads.
- `LG_CLOSED`: the youngest load group is a fence or also writes memory, or an aliasing store has been dispatched after it.

The retire input frees one load-queue entry and the commit input frees one store-queue entry. A queue depth of zero means that queue never fills.

Top module: `mo_dispatch`

## Requirements
- R1: A queue reports full only when its depth parameter is nonzero and its occupancy equals the depth. The occupancy used here already counts any retire or commit arriving in the same cycle. A queue with depth 0 never reports full.
- R2: `status_o` is 0 when the operation is available. It is 1 when the operation reads memory and the load queue is full. Otherwise it is 2 when the operation writes memory and the store queue is full. An operation with neither memory flag always reads 0.
- R3: An operation is accepted only when it is valid, has at least one memory flag and its status is 0. Each accepted operation takes exactly one entry in each queue whose flag it carries. A retire or commit that arrives while its queue is empty has no effect.
- R4: Every accepted operation that writes memory opens a new group. That group has an edge to the current store group and an edge to the current load group, whenever those groups exist, whatever `NO_ALIAS` says. The new group then becomes the current store group.
- R5: A new group for a load has an edge to the current store group only when `NO_ALIAS` is 0.
- R6: A plain load (read flag only) accepted in `LG_OPEN` joins the current load group. It returns that group's number, opens no new group and emits no edges.
- R7: A load with side effects has edges to the current load group and to the current load-fence group. It becomes both the current load group and the current load-fence group. Every plain load opening a new group has an edge to the current load-fence group.
- R8: When two edges would name the same group, only one edge is emitted, with priority store edge, then load edge, then fence edge. A full fence becomes the current load, store and load-fence group.
- R9: `gid_o` and every invalid edge's group output read 0 unless the operation is accepted. New groups are numbered from 1 upwards and wrap from 2^GID_W-1 back to 1, never using 0.
- R10: After reset no group exists, so the first operation emits no edges. Both queues are empty, the first group number is 1 and the state is `LG_NONE`.
- R11: Accepted state-machine transitions are as follows.
  - T_OPEN: a plain load moves to `LG_OPEN`.
  - T_SEAL: a load with side effects or a write flag moves to `LG_CLOSED`.
  - T_ALIAS: a store-only operation in `LG_OPEN` with `NO_ALIAS` 0 moves to `LG_CLOSED`.
  - All other accepted operations keep the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An operation is presented this cycle |
| disp_load | input | 1 | Operation may read memory |
| disp_store | input | 1 | Operation may write memory |
| disp_side | input | 1 | Operation has side effects (fence) |
| ld_retire | input | 1 | Free one load-queue entry |
| st_commit | input | 1 | Free one store-queue entry |
| status_o | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| accept_o | output | 1 | Operation accepted this cycle |
| gid_o | output | GID_W | Group number given to the operation |
| dep_st_vld_o | output | 1 | Edge to the store group is present |
| dep_st_gid_o | output | GID_W | Store group waited on |
| dep_ld_vld_o | output | 1 | Edge to the load group is present |
| dep_ld_gid_o | output | GID_W | Load group waited on |
| dep_bar_vld_o | output | 1 | Edge to the load-fence group is present |
| dep_bar_gid_o | output | GID_W | Load-fence group waited on |

## Verification
Any error in the stored current-group numbers shows up on the edge outputs at the very next operation that needs that group. This happens in the same cycle as that operation, because edges are combinational from the stored state.

A wrong state-machine state shows up on the next plain load: it either wrongly joins a group (`gid_o` repeats and the edges disappear) or wrongly opens one (`gid_o` advances).

An occupancy count that is off by one shows up as a status change one operation early or late at the full boundary. The bench runs two configurations side by side, aliasing with bounded queues and no-alias with an unbounded load queue, so that both the alias rule and the unbounded case are compared cycle by cycle.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [1:0] {
        AV_OK      = 2'd0,
        AV_LQ_FULL = 2'd1,
        AV_SQ_FULL = 2'd2
    } avail_e;

    typedef enum logic [1:0] {
        LG_NONE   = 2'd0,
        LG_OPEN   = 2'd1,
        LG_CLOSED = 2'd2
    } lg_state_e;

endpackage

// File: rtl/mo_queue_ctr.sv
module mo_queue_ctr #(
    parameter int DEPTH = 4,
    parameter int UNB_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic rel_i,
    output logic full_o
);
    localparam int CNT_W = (DEPTH == 0) ? UNB_W : $clog2(DEPTH + 1);

    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] used_eff;

    always_comb begin
        used_eff = used_q - CNT_W'(rel_i && (used_q != '0));
    end

    generate
        if (DEPTH == 0) begin : g_unbounded
            assign full_o = 1'b0;
        end else begin : g_bounded
            assign full_o = (used_eff == CNT_W'(DEPTH));

            // R1: bounded occupancy never exceeds the depth
            a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                used_q <= CNT_W'(DEPTH));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            used_q <= used_eff + CNT_W'(take_i);
        end
    end

    // R3: an entry is never taken from a full queue
    a_r3_take_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !take_i);

endmodule

// File: rtl/mo_gid_alloc.sv
module mo_gid_alloc #(
    parameter int GID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [GID_W-1:0] id_o
);
    localparam logic [GID_W-1:0] ID_MAX = '1;
    localparam logic [GID_W-1:0] ID_FIRST = GID_W'(1);

    logic [GID_W-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= ID_FIRST;
        end else if (adv_i) begin
            id_q <= (id_q == ID_MAX) ? ID_FIRST : id_q + ID_FIRST;
        end
    end

    assign id_o = id_q;

    // R9: zero is reserved and never handed out
    a_r9_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        id_o != '0);

    // R9: numbering wraps from the top value back to one
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && id_o == ID_MAX) |=> id_o == ID_FIRST);

endmodule

// File: rtl/mo_dispatch.sv
module mo_dispatch
    import mo_pkg::*;
#(
    parameter int GID_W    = 4,
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 3,
    parameter int UNB_W    = 8,
    parameter bit NO_ALIAS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_load,
    input  logic             disp_store,
    input  logic             disp_side,
    input  logic             ld_retire,
    input  logic             st_commit,
    output logic [1:0]       status_o,
    output logic             accept_o,
    output logic [GID_W-1:0] gid_o,
    output logic             dep_st_vld_o,
    output logic [GID_W-1:0] dep_st_gid_o,
    output logic             dep_ld_vld_o,
    output logic [GID_W-1:0] dep_ld_gid_o,
    output logic             dep_bar_vld_o,
    output logic [GID_W-1:0] dep_bar_gid_o
);
    lg_state_e        state_q, state_d;
    avail_e           status;
    logic             lq_full, sq_full;
    logic             accept, join_grp, new_grp;
    logic             st_e, ld_e, bar_e;
    logic [GID_W-1:0] alloc_id, gid;
    logic [GID_W-1:0] cur_ld_q, cur_st_q, cur_bar_q;

    mo_queue_ctr #(.DEPTH(LQ_DEPTH), .UNB_W(UNB_W)) u_lq (
        .clk(clk), .rst_n(rst_n),
        .take_i(accept && disp_load), .rel_i(ld_retire), .full_o(lq_full)
    );

    mo_queue_ctr #(.DEPTH(SQ_DEPTH), .UNB_W(UNB_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .take_i(accept && disp_store), .rel_i(st_commit), .full_o(sq_full)
    );

    mo_gid_alloc #(.GID_W(GID_W)) u_gid (
        .clk(clk), .rst_n(rst_n), .adv_i(new_grp), .id_o(alloc_id)
    );

    // State register and current-group registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LG_NONE;
            cur_ld_q  <= '0;
            cur_st_q  <= '0;
            cur_bar_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && disp_store)              cur_st_q  <= gid;
            if (accept && disp_load)               cur_ld_q  <= gid;
            if (accept && disp_load && disp_side)  cur_bar_q <= gid;
        end
    end

    // Next state: T_OPEN, T_SEAL, T_ALIAS
    always_comb begin
        state_d = state_q;
        if (accept) begin
            unique case (state_q)
                LG_NONE, LG_CLOSED: begin
                    if (disp_load)
                        state_d = (disp_store || disp_side) ? LG_CLOSED : LG_OPEN;
                end
                LG_OPEN: begin
                    if (disp_load)
                        state_d = (disp_store || disp_side) ? LG_CLOSED : LG_OPEN;
                    else if (!NO_ALIAS)
                        state_d = LG_CLOSED;
                end
                default: state_d = LG_NONE;
            endcase
        end
    end

    // Outputs: status, acceptance, group number and ordering edges
    always_comb begin
        status = AV_OK;
        if (disp_load && lq_full)
            status = AV_LQ_FULL;
        else if (disp_store && sq_full)
            status = AV_SQ_FULL;

        accept   = disp_valid && (disp_load || disp_store) && (status == AV_OK);
        join_grp = accept && disp_load && !disp_store && !disp_side
                   && (state_q == LG_OPEN);
        new_grp  = accept && !join_grp;

        gid = '0;
        if (join_grp)     gid = cur_ld_q;
        else if (new_grp) gid = alloc_id;

        st_e  = new_grp && (cur_st_q != '0)
                && (disp_store || (disp_load && !NO_ALIAS));
        ld_e  = new_grp && (cur_ld_q != '0)
                && (disp_store || (disp_load && disp_side))
                && !(st_e && cur_ld_q == cur_st_q);
        bar_e = new_grp && disp_load && (cur_bar_q != '0)
                && !(st_e && cur_bar_q == cur_st_q)
                && !(ld_e && cur_bar_q == cur_ld_q);
    end

    assign status_o      = status;
    assign accept_o      = accept;
    assign gid_o         = gid;
    assign dep_st_vld_o  = st_e;
    assign dep_st_gid_o  = st_e  ? cur_st_q  : '0;
    assign dep_ld_vld_o  = ld_e;
    assign dep_ld_gid_o  = ld_e  ? cur_ld_q  : '0;
    assign dep_bar_vld_o = bar_e;
    assign dep_bar_gid_o = bar_e ? cur_bar_q : '0;

    // R2: a nonzero status refuses the operation in the same cycle
    a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd0) |-> !accept_o);

    // R9: an accepted operation always carries a real group number
    a_r9_accept_gid: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> gid_o != '0);

    // R4: an accepted store becomes the current store group
    a_r4_store_tracked: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && disp_store) |=> cur_st_q == $past(gid_o));

    // R11: a fence load always leaves the load group closed
    a_r11_fence_seals: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && disp_load && disp_side) |=> state_q == LG_CLOSED);

    // R6: a joining load emits no edge
    a_r6_join_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && state_q == LG_OPEN && disp_load && !disp_store && !disp_side)
        |-> (!dep_st_vld_o && !dep_ld_vld_o && !dep_bar_vld_o));

endmodule

// File: tb/mo_dispatch_bench.sv
`timescale 1ns/1ps
module mo_dispatch_bench;
    localparam int GW = 4;
    localparam int IDMAX = (1 << GW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_load = 0, disp_store = 0, disp_side = 0;
    logic ld_retire = 0, st_commit = 0;

    logic [1:0]    w_stat [2];
    logic          w_acc  [2];
    logic [GW-1:0] w_gid  [2];
    logic          w_sv [2], w_lv [2], w_bv [2];
    logic [GW-1:0] w_sg [2], w_lg [2], w_bg [2];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state, index 0: aliasing LQ 4 SQ 3; index 1: no-alias LQ unbounded SQ 3
    int m_lqd [2] = '{4, 0};
    int m_sqd [2] = '{3, 3};
    int m_na  [2] = '{0, 1};
    int m_lq [2], m_sq [2], m_cl [2], m_cs [2], m_cb [2], m_nid [2], m_st [2];

    always #4 clk = ~clk;

    mo_dispatch #(.GID_W(GW), .LQ_DEPTH(4), .SQ_DEPTH(3), .NO_ALIAS(1'b0)) u_mo_dispatch (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_load(disp_load),
        .disp_store(disp_store), .disp_side(disp_side), .ld_retire(ld_retire),
        .st_commit(st_commit), .status_o(w_stat[0]), .accept_o(w_acc[0]), .gid_o(w_gid[0]),
        .dep_st_vld_o(w_sv[0]), .dep_st_gid_o(w_sg[0]), .dep_ld_vld_o(w_lv[0]),
        .dep_ld_gid_o(w_lg[0]), .dep_bar_vld_o(w_bv[0]), .dep_bar_gid_o(w_bg[0])
    );

    mo_dispatch #(.GID_W(GW), .LQ_DEPTH(0), .SQ_DEPTH(3), .NO_ALIAS(1'b1)) u_mo_dispatch_na (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_load(disp_load),
        .disp_store(disp_store), .disp_side(disp_side), .ld_retire(ld_retire),
        .st_commit(st_commit), .status_o(w_stat[1]), .accept_o(w_acc[1]), .gid_o(w_gid[1]),
        .dep_st_vld_o(w_sv[1]), .dep_st_gid_o(w_sg[1]), .dep_ld_vld_o(w_lv[1]),
        .dep_ld_gid_o(w_lg[1]), .dep_bar_vld_o(w_bv[1]), .dep_bar_gid_o(w_bg[1])
    );

    task automatic check(input int k, input string what, input string tag,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s inst%0d %s: actual %0d expected %0d", tag, k, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic l, input logic s, input logic e,
                        input logic r, input logic c, input string tag);
        @(negedge clk);
        disp_valid = v; disp_load = l; disp_store = s; disp_side = e;
        ld_retire = r; st_commit = c;
        #2;
        for (int k = 0; k < 2; k++) begin
            int lqe, sqe, es, eg;
            bit lf, sf, acc, jn, ng, est, eld, ebar;
            lqe = m_lq[k] - ((r && m_lq[k] > 0) ? 1 : 0);
            sqe = m_sq[k] - ((c && m_sq[k] > 0) ? 1 : 0);
            lf = (m_lqd[k] != 0) && (lqe == m_lqd[k]);
            sf = (m_sqd[k] != 0) && (sqe == m_sqd[k]);
            es = (l && lf) ? 1 : ((s && sf) ? 2 : 0);
            acc = v && (l || s) && (es == 0);
            jn = acc && l && !s && !e && (m_st[k] == 1);
            ng = acc && !jn;
            eg = jn ? m_cl[k] : (ng ? m_nid[k] : 0);
            est = ng && (m_cs[k] != 0) && (s || (l && m_na[k] == 0));
            eld = ng && (m_cl[k] != 0) && (s || (l && e)) && !(est && m_cl[k] == m_cs[k]);
            ebar = ng && l && (m_cb[k] != 0) && !(est && m_cb[k] == m_cs[k])
                   && !(eld && m_cb[k] == m_cl[k]);
            check(k, "status", tag, int'(w_stat[k]), es);
            check(k, "accept", tag, int'(w_acc[k]), int'(acc));
            check(k, "gid", tag, int'(w_gid[k]), eg);
            check(k, "st_edge", tag, int'(w_sv[k]), int'(est));
            check(k, "st_gid", tag, int'(w_sg[k]), est ? m_cs[k] : 0);
            check(k, "ld_edge", tag, int'(w_lv[k]), int'(eld));
            check(k, "ld_gid", tag, int'(w_lg[k]), eld ? m_cl[k] : 0);
            check(k, "bar_edge", tag, int'(w_bv[k]), int'(ebar));
            check(k, "bar_gid", tag, int'(w_bg[k]), ebar ? m_cb[k] : 0);
            m_lq[k] = lqe + ((acc && l) ? 1 : 0);
            m_sq[k] = sqe + ((acc && s) ? 1 : 0);
            if (ng) m_nid[k] = (m_nid[k] == IDMAX) ? 1 : m_nid[k] + 1;
            if (acc) begin
                if (s) m_cs[k] = eg;
                if (l) m_cl[k] = eg;
                if (l && e) m_cb[k] = eg;
                if (l) m_st[k] = (s || e) ? 2 : 1;
                else if (m_na[k] == 0 && m_st[k] == 1) m_st[k] = 2;
            end
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_lq[k] = 0; m_sq[k] = 0; m_cl[k] = 0; m_cs[k] = 0;
            m_cb[k] = 0; m_nid[k] = 1; m_st[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R10 idle after reset");
        step(1, 1, 0, 0, 0, 0, "R10 first load no edges");
        step(1, 1, 0, 0, 0, 0, "R6 load joins open group");
        step(1, 0, 1, 0, 0, 0, "R4 store after loads");
        step(1, 1, 0, 0, 0, 0, "R5 load after store alias setting");
        step(1, 1, 0, 0, 0, 0, "R11 open again");
        step(1, 1, 0, 0, 0, 0, "R2 load queue reaches full");
        step(1, 1, 0, 0, 1, 0, "R1 retire same cycle frees room");
        step(1, 1, 0, 0, 0, 0, "R2 load refused when full");
        step(1, 0, 1, 0, 0, 0, "R4 second store");
        step(1, 0, 1, 0, 0, 0, "R4 third store");
        step(1, 0, 1, 0, 0, 0, "R2 store refused when full");
        step(1, 0, 1, 0, 0, 1, "R1 commit same cycle frees room");
        step(1, 0, 0, 1, 0, 0, "R2 non-memory op available");
        step(0, 1, 1, 0, 0, 0, "R3 invalid not accepted");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 1, "R3 drain queues");
        step(0, 0, 0, 0, 1, 1, "R3 release on empty ignored");
        step(1, 1, 0, 1, 0, 0, "R7 load fence");
        step(1, 1, 0, 0, 0, 0, "R7 plain load after fence");
        step(1, 1, 0, 0, 0, 0, "R6 join after fence group");
        step(1, 0, 1, 1, 0, 0, "R4 store fence");
        step(1, 0, 1, 0, 0, 0, "R4 store after store fence");
        step(1, 1, 1, 1, 1, 1, "R8 full fence");
        step(1, 0, 1, 0, 1, 1, "R8 duplicate edge suppressed");
        step(1, 1, 0, 0, 1, 1, "R8 load after full fence");
        step(1, 1, 0, 0, 0, 0, "R1 load fill 2");
        step(1, 1, 0, 0, 0, 0, "R1 load fill 3");
        step(1, 1, 0, 0, 0, 0, "R1 load fill 4");
        step(1, 1, 0, 0, 0, 0, "R1 full at exactly depth");
        step(1, 1, 1, 0, 0, 0, "R2 load queue wins priority");
        for (int i = 0; i < 20; i++) step(1, 1, 1, 0, 1, 1, "R9 numbering wraps");
        step(1, 1, 0, 1, 1, 1, "R7 fence after wrap");
        step(1, 0, 1, 0, 1, 1, "R11 store-only keeps state");
        step(1, 1, 0, 0, 1, 1, "R5 load after store");
        step(1, 0, 1, 0, 1, 1, "R11 alias closes open group");
        step(1, 1, 0, 0, 1, 1, "R6 load after closing store");
        step(0, 0, 0, 0, 0, 0, "R9 idle gid zero");
        done = 1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

endmodule